// File: doc/BRIEF.md
# Transmit Framing Event Timer

This block tracks the position of the transmitter inside its framing structure and tells a host when to refresh per-multiframe overhead and signaling data. A frame-start strobe arrives once per 125 µs frame. The block counts these strobes and raises one-cycle event pulses at the boundaries the selected framing format defines. It also reports the index of the current frame inside the multiframe.

A two-bit mode input selects the format. T1 superframe has 12 frames per multiframe, T1 extended superframe has 24, and E1 has 16. The E1 multiframe length does not depend on whether CRC-4 is in use. In E1 mode a second pulse marks every frame pair (250 µs), so the host can refresh alternating frame overhead. In T1 mode an optional 72-frame counter can be enabled to mark the SLC-96 data-link period. This counter runs apart from the multiframe counter. A change of mode restarts all counting from zero.

Top module: `txframe_timer`

## Requirements
- R1: After reset, all three event outputs are low and the frame index is zero.
- R2: With mode 00 (T1 superframe), the frame index steps 0..11 on successive strobes, and the multiframe event fires on every 12th strobe, in the same cycle as the index returns to zero.
- R3: With mode 01 (T1 extended superframe), the multiframe event fires on every 24th strobe and the index steps 0..23.
- R4: With mode bit 1 set (10 or 11, E1), the multiframe event fires on every 16th strobe and the index stays in 0..15.
- R5: In E1 the align event fires on every second strobe, namely each strobe that arrives while the index is odd. It never fires in either T1 mode.
- R6: In a T1 mode with the SLC enable high, the SLC event fires on every 72nd strobe, counted from enable or from the last mode change. The multiframe phase does not affect this count.
- R7: With the SLC enable low, or in E1, the SLC event never fires and its count is held at zero. After enable, the first SLC event comes on the 72nd strobe.
- R8: Any change of the mode input sets the frame index and both counts to zero. The next multiframe event then comes a full period of the new mode later.
- R9: Events and the index update are registered. A pulse is high for exactly the one cycle after the clock edge that sampled the strobe, and every event output is low in cycles that do not follow a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle frame-start strobe, one per frame |
| txMode | input | 2 | 00 T1 superframe, 01 T1 extended superframe, 1x E1 |
| slcEnable | input | 1 | Enables the 72-frame event in T1 modes |
| mfEvent | output | 1 | Multiframe boundary pulse |
| alignEvent | output | 1 | E1 frame-pair pulse |
| slcEvent | output | 1 | 72-frame period pulse |
| frameIndex | output | 5 (FRAME_W) | Frame position inside the current multiframe |

## Verification
The following invariants are checked on every cycle:
- Every event follows a sampled strobe.
- A multiframe or SLC pulse coincides with its counter at zero.
- The align pulse appears only in E1 and is never high two cycles running.
- The SLC pulse appears only when the option was on.
- The index stays inside the selected multiframe.
- A mode change leaves the index at zero.

Only the bench scenarios can show the actual periods of 12, 24, 16, 2 and 72 strobes. The same holds for the phase restart after a mode change or after re-enabling the SLC counter, and for the independence of the SLC count from the multiframe phase. The bench covers these with varied strobe spacing, back-to-back strobes and mid-multiframe switches.

// File: rtl/txframe_timer_pkg.sv
package txframe_timer_pkg;

  typedef enum logic [1:0] {
    TXM_T1_SF  = 2'b00,
    TXM_T1_ESF = 2'b01,
    TXM_E1     = 2'b10,
    TXM_E1_ALT = 2'b11
  } tx_mode_e;

  // Strobes from the control to the counting datapath
  typedef struct packed {
    logic clearFrame;
    logic stepFrame;
    logic wrapFrame;
    logic alignHit;
    logic slcClear;
    logic slcStep;
    logic slcWrap;
  } timer_ctrl_t;

endpackage

// File: rtl/txframe_timer_ctrl.sv
module txframe_timer_ctrl
  import txframe_timer_pkg::*;
#(
  parameter int SF_LEN  = 12,
  parameter int ESF_LEN = 24,
  parameter int E1_LEN  = 16,
  parameter int SLC_LEN = 72,
  parameter int FRAME_W = 5,
  parameter int SLC_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStrobe,
  input  logic [1:0]         txMode,
  input  logic               slcEnable,
  input  logic [FRAME_W-1:0] frameCount,
  input  logic [SLC_W-1:0]   slcCount,
  output timer_ctrl_t        ctrl,
  output logic               isE1,
  output logic               slcOn
);

  localparam logic [FRAME_W-1:0] SF_LAST  = FRAME_W'(SF_LEN - 1);
  localparam logic [FRAME_W-1:0] ESF_LAST = FRAME_W'(ESF_LEN - 1);
  localparam logic [FRAME_W-1:0] E1_LAST  = FRAME_W'(E1_LEN - 1);
  localparam logic [SLC_W-1:0]   SLC_LAST = SLC_W'(SLC_LEN - 1);

  logic [1:0]         modeQ;
  logic               modeChange;
  logic [FRAME_W-1:0] lastIdx;
  logic               frameLast;
  logic               slcLast;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= TXM_T1_SF;
    else       modeQ <= txMode;
  end

  assign modeChange = (txMode != modeQ);
  assign isE1       = txMode[1];
  assign slcOn      = slcEnable && !isE1;

  always_comb begin
    unique case (tx_mode_e'(txMode))
      TXM_T1_SF:  lastIdx = SF_LAST;
      TXM_T1_ESF: lastIdx = ESF_LAST;
      default:    lastIdx = E1_LAST;
    endcase
  end

  assign frameLast = (frameCount >= lastIdx);
  assign slcLast   = (slcCount >= SLC_LAST);

  always_comb begin
    ctrl            = '0;
    ctrl.clearFrame = modeChange;
    ctrl.stepFrame  = frameStrobe && !modeChange;
    ctrl.wrapFrame  = ctrl.stepFrame && frameLast;
    ctrl.alignHit   = ctrl.stepFrame && isE1 && frameCount[0];
    ctrl.slcClear   = modeChange || !slcOn;
    ctrl.slcStep    = ctrl.stepFrame && slcOn;
    ctrl.slcWrap    = ctrl.slcStep && slcLast;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !modeChange |-> frameCount <= lastIdx); // R4

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> (frameCount == '0 && slcCount == '0)); // R8

endmodule

// File: rtl/txframe_timer_dp.sv
module txframe_timer_dp
  import txframe_timer_pkg::*;
#(
  parameter int FRAME_W = 5,
  parameter int SLC_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  timer_ctrl_t        ctrl,
  input  logic               isE1,
  input  logic               slcOn,
  output logic [FRAME_W-1:0] frameCount,
  output logic [SLC_W-1:0]   slcCount,
  output logic               mfEvent,
  output logic               alignEvent,
  output logic               slcEvent
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount <= '0;
    end else if (ctrl.clearFrame || ctrl.wrapFrame) begin
      frameCount <= '0;
    end else if (ctrl.stepFrame) begin
      frameCount <= frameCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slcCount <= '0;
    end else if (ctrl.slcClear || ctrl.slcWrap) begin
      slcCount <= '0;
    end else if (ctrl.slcStep) begin
      slcCount <= slcCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mfEvent    <= 1'b0;
      alignEvent <= 1'b0;
      slcEvent   <= 1'b0;
    end else begin
      mfEvent    <= ctrl.wrapFrame;
      alignEvent <= ctrl.alignHit;
      slcEvent   <= ctrl.slcWrap;
    end
  end

  AST_MF_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    mfEvent |-> frameCount == '0); // R2

  AST_SLC_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    slcEvent |-> slcCount == '0); // R6

  AST_ALIGN_E1: assert property (@(posedge clk) disable iff (!rstN)
    alignEvent |-> $past(isE1)); // R5

  AST_SLC_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    slcEvent |-> $past(slcOn)); // R7

  AST_ALIGN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    alignEvent |=> !alignEvent); // R9

endmodule

// File: rtl/txframe_timer.sv
module txframe_timer
  import txframe_timer_pkg::*;
#(
  parameter int SF_LEN  = 12,
  parameter int ESF_LEN = 24,
  parameter int E1_LEN  = 16,
  parameter int SLC_LEN = 72,
  localparam int MF_MAX  = (SF_LEN > ESF_LEN) ? ((SF_LEN > E1_LEN) ? SF_LEN : E1_LEN)
                                              : ((ESF_LEN > E1_LEN) ? ESF_LEN : E1_LEN),
  localparam int FRAME_W = $clog2(MF_MAX),
  localparam int SLC_W   = $clog2(SLC_LEN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStrobe,
  input  logic [1:0]         txMode,
  input  logic               slcEnable,
  output logic               mfEvent,
  output logic               alignEvent,
  output logic               slcEvent,
  output logic [FRAME_W-1:0] frameIndex
);

  timer_ctrl_t        ctrl;
  logic               isE1;
  logic               slcOn;
  logic [FRAME_W-1:0] frameCount;
  logic [SLC_W-1:0]   slcCount;

  txframe_timer_ctrl #(
    .SF_LEN(SF_LEN), .ESF_LEN(ESF_LEN), .E1_LEN(E1_LEN), .SLC_LEN(SLC_LEN),
    .FRAME_W(FRAME_W), .SLC_W(SLC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .txMode(txMode),
    .slcEnable(slcEnable), .frameCount(frameCount), .slcCount(slcCount),
    .ctrl(ctrl), .isE1(isE1), .slcOn(slcOn)
  );

  txframe_timer_dp #(
    .FRAME_W(FRAME_W), .SLC_W(SLC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .isE1(isE1), .slcOn(slcOn),
    .frameCount(frameCount), .slcCount(slcCount),
    .mfEvent(mfEvent), .alignEvent(alignEvent), .slcEvent(slcEvent)
  );

  assign frameIndex = frameCount;

  AST_EVENT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (mfEvent || alignEvent || slcEvent) |-> $past(frameStrobe)); // R9

endmodule

// File: tb/txframe_timer_bench.sv
`timescale 1ns/100ps
module txframe_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStrobe = 1'b0;
  logic [1:0] txMode = 2'b00;
  logic       slcEnable = 1'b0;
  logic       mfEvent, alignEvent, slcEvent;
  logic [4:0] frameIndex;

  int testCount = 0;
  int failCount = 0;

  typedef struct {
    bit    mf;
    bit    slc;
    bit    align;
    int    idx;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   mCnt = 0;
  int   mSlc = 0;
  logic strobeSampled = 1'b0;

  always #2.5 clk = ~clk;

  txframe_timer u_txframe_timer (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .txMode(txMode),
    .slcEnable(slcEnable), .mfEvent(mfEvent), .alignEvent(alignEvent),
    .slcEvent(slcEvent), .frameIndex(frameIndex)
  );

  always @(posedge clk) strobeSampled <= rstN && frameStrobe;

  // Driver: one frame strobe, expected result pushed to the scoreboard
  task automatic sendFrame(input int gap, input string tag);
    exp_t e;
    bit   e1;
    int   len;
    @(negedge clk);
    frameStrobe = 1'b1;
    e1  = txMode[1];
    len = e1 ? 16 : (txMode[0] ? 24 : 12);
    e.tag   = tag;
    e.align = e1 && (mCnt % 2 == 1);
    e.mf    = (mCnt == len - 1);
    mCnt    = e.mf ? 0 : mCnt + 1;
    e.idx   = mCnt;
    if (!e1 && slcEnable) begin
      e.slc = (mSlc == 71);
      mSlc  = e.slc ? 0 : mSlc + 1;
    end else begin
      e.slc = 1'b0;
      mSlc  = 0;
    end
    expQ.push_back(e);
    repeat (gap) begin
      @(negedge clk);
      frameStrobe = 1'b0;
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    frameStrobe = 1'b0;
    txMode = m;
    mCnt = 0;
    mSlc = 0;
  endtask

  task automatic setSlc(input logic en);
    @(negedge clk);
    frameStrobe = 1'b0;
    slcEnable = en;
    if (!en) mSlc = 0;
  endtask

  task automatic runFrames(input int n, input string tag);
    for (int i = 0; i < n; i++) sendFrame(i % 3, tag);
  endtask

  // Monitor: compares each cycle's outputs against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (strobeSampled) begin
        if (expQ.size() == 0) begin
          testCount++; failCount++;
          $display("FAIL R9: strobe sampled but scoreboard empty");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          testCount++;
          if (mfEvent !== e.mf || slcEvent !== e.slc || alignEvent !== e.align
              || frameIndex !== 5'(e.idx)) begin
            failCount++;
            $display("FAIL %s: mf=%0b slc=%0b align=%0b idx=%0d expected mf=%0b slc=%0b align=%0b idx=%0d",
                     e.tag, mfEvent, slcEvent, alignEvent, frameIndex,
                     e.mf, e.slc, e.align, e.idx);
          end
        end
      end else begin
        testCount++;
        if (mfEvent !== 1'b0 || slcEvent !== 1'b0 || alignEvent !== 1'b0) begin
          failCount++;
          $display("FAIL R9: idle cycle mf=%0b slc=%0b align=%0b expected 0 0 0",
                   mfEvent, slcEvent, alignEvent);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testCount++;
    if (mfEvent !== 1'b0 || slcEvent !== 1'b0 || alignEvent !== 1'b0 || frameIndex !== 5'd0) begin
      failCount++;
      $display("FAIL R1: mf=%0b slc=%0b align=%0b idx=%0d expected 0 0 0 0",
               mfEvent, slcEvent, alignEvent, frameIndex);
    end
    // R2 superframe, mixed spacing
    runFrames(30, "R2");
    // R8 switch mid-multiframe, then R3 extended superframe back-to-back
    setMode(2'b01);
    for (int i = 0; i < 24; i++) sendFrame(0, "R8");
    for (int i = 0; i < 26; i++) sendFrame(0, "R3");
    // R6 SLC period, out of phase with the multiframe
    setSlc(1'b1);
    runFrames(160, "R6");
    // R7 disable holds zero, re-enable restarts a full period
    setSlc(1'b0);
    runFrames(20, "R7");
    setSlc(1'b1);
    runFrames(75, "R7");
    // R8 back to superframe with SLC still on
    setMode(2'b00);
    runFrames(30, "R8");
    // R4 R5 E1 (SLC enable left high: R7)
    setMode(2'b10);
    runFrames(40, "R4 R5 R7");
    setMode(2'b11);
    runFrames(20, "R4 R5");
    @(negedge clk);
    frameStrobe = 1'b0;
    repeat (4) @(negedge clk);
    testCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R9: %0d results missing, expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule